// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit timer/counter. It keeps its count as a low byte and a high byte, has a second 16-bit byte pair (the holding register) that either latches the count or supplies a reload value, and has one control byte. Software reaches all five byte registers through a byte-wide write port with a combinational read-back. The counter advances on one of two sources: an internal enable that pulses once per machine cycle, or falling edges seen on an external count pin. A separate trigger pin can capture the count or force a reload.

Three modes are available. Capture mode lets the counter wrap freely and copies the count into the holding register on a trigger edge. Auto-reload mode reloads the counter from the holding register when it overflows or when a trigger edge arrives. Baud generator mode reloads on overflow and sends a one-cycle tick to a serial port instead of raising the overflow flag. In that mode the internal source advances on every clock cycle, not once per machine cycle. Two sticky flags, overflow and trigger, go to an interrupt controller.

Top module: `cr_timer`

## Requirements
- R1: After reset, all five registers read 0, both flags are low and baud_tick is low.
- R2: The reg_addr map is: 0 control, 1 count low, 2 count high, 3 holding low, 4 holding high. Addresses 5 to 7 read 0, and writes to them have no effect. Control bits are: bit0 run, bit1 source (1 = external pin), bits3:2 mode (00 capture, 01 auto-reload, 10 or 11 baud), bit4 trigger enable, bit5 reads 0, bit6 overflow flag, bit7 trigger flag. Reads are combinational. A write takes effect at the next clock edge.
- R3: With run=1, source internal and a capture or auto-reload mode, the count rises by 1 on each cycle where tick_en is high. With run=0 the count only changes through writes or reloads.
- R4: With source external and run=1, the count rises by 1 on a tick_en cycle where ext_cnt is 0 and was 1 at the previous tick_en cycle.
- R5: In capture mode, a count step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: In capture mode with trigger enable set, a trigger edge loads the holding register with the count as it was before that cycle's step and sets the trigger flag. A trigger edge is ext_trig sampled 0 on a tick_en cycle after being 1 at the previous tick_en cycle. With trigger enable clear, an edge changes nothing.
- R7: In auto-reload mode, a step from 0xFFFF loads the holding value and sets the overflow flag.
- R8: In auto-reload mode, an enabled trigger edge loads the holding value, sets the trigger flag and replaces that cycle's step. It works with run=0.
- R9: In baud mode, the internal source steps on every clock cycle. A step from 0xFFFF loads the holding value and drives baud_tick high for the next cycle only, and the overflow flag is left unchanged. An enabled trigger edge only sets the trigger flag.
- R10: Flags stay set until a control write puts a 0 in their bit. A hardware set in the same cycle as such a write wins.
- R11: A write to either count byte cancels that cycle's step and reload. A write to either holding byte cancels that cycle's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per machine cycle |
| ext_cnt | input | 1 | External count pin |
| ext_trig | input | 1 | Capture/reload trigger pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ovf_flag | output | 1 | Sticky overflow flag |
| trig_flag | output | 1 | Sticky trigger flag |
| baud_tick | output | 1 | One-cycle serial clock tick |

## Verification
The bench loads a count near 0xFFFF in each mode and source, so overflows happen often. A design that wrapped to zero in reload mode, or raised the overflow flag in baud mode, would read back a wrong count or a wrong flag. Trigger edges are mixed with overflows and with runs where run is off, so a capture that latched the incremented value, or a reload that ignored a stopped counter, shows up in the holding or count read-back. Collisions of register writes with steps and flag sets check that a write cancels a step, and that a flag clear does not hide a flag set in the same cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;
    parameter int BYTE_W = 8;
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [1:0] MODE_CAP = 2'b00;
    localparam logic [1:0] MODE_RLD = 2'b01;
    localparam logic [2:0] A_CTL = 3'd0;
    localparam logic [2:0] A_CNTL = 3'd1;
    localparam logic [2:0] A_CNTH = 3'd2;
    localparam logic [2:0] A_HLDL = 3'd3;
    localparam logic [2:0] A_HLDH = 3'd4;

    typedef struct packed {
        logic             run;
        logic             src;
        logic [1:0]       mode;
        logic             trig_en;
        logic             ovf;
        logic             trg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             baud;
    } crt_state_t;
endpackage

// File: rtl/crt_edge.sv
module crt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic pin,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sample_en ? pin : prev_q;
        fall   = sample_en & prev_q & ~pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/crt_count.sv
module crt_count
    import crt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cnt_fall,
    input  logic              trg_fall,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output crt_state_t        st_q
);
    crt_state_t d;
    logic is_baud, is_rld, is_cap, step, trg_hit, at_top;
    logic wr_ctl, wr_cl, wr_ch, wr_hl, wr_hh;

    always_comb begin
        d       = st_q;
        d.baud  = 1'b0;
        is_baud = st_q.mode[1];
        is_rld  = (st_q.mode == MODE_RLD);
        is_cap  = (st_q.mode == MODE_CAP);
        step    = st_q.run & (st_q.src ? cnt_fall : (is_baud | tick_en));
        trg_hit = st_q.trig_en & trg_fall;
        at_top  = (st_q.cnt == {CNT_W{1'b1}});
        wr_ctl  = we && (addr == ADDR_W'(A_CTL));
        wr_cl   = we && (addr == ADDR_W'(A_CNTL));
        wr_ch   = we && (addr == ADDR_W'(A_CNTH));
        wr_hl   = we && (addr == ADDR_W'(A_HLDL));
        wr_hh   = we && (addr == ADDR_W'(A_HLDH));

        if (wr_ctl) begin
            d.run     = wdata[0];
            d.src     = wdata[1];
            d.mode    = wdata[3:2];
            d.trig_en = wdata[4];
            d.ovf     = wdata[6];
            d.trg     = wdata[7];
        end

        if (wr_cl || wr_ch) begin
            if (wr_cl) d.cnt[BYTE_W-1:0]     = wdata;
            if (wr_ch) d.cnt[CNT_W-1:BYTE_W] = wdata;
        end else if (is_rld && trg_hit) begin
            d.cnt = st_q.hold;
        end else if (step) begin
            if (at_top) begin
                d.cnt = is_cap ? '0 : st_q.hold;
                if (is_baud) d.baud = 1'b1;
                else         d.ovf  = 1'b1;
            end else begin
                d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (wr_hl || wr_hh) begin
            if (wr_hl) d.hold[BYTE_W-1:0]     = wdata;
            if (wr_hh) d.hold[CNT_W-1:BYTE_W] = wdata;
        end else if (is_cap && trg_hit) begin
            d.hold = st_q.cnt;
        end

        if (trg_hit) d.trg = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= d;
    end
endmodule

// File: rtl/crt_rdmux.sv
module crt_rdmux
    import crt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  crt_state_t        st,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        case (addr)
            ADDR_W'(A_CTL):  rdata = {st.trg, st.ovf, 1'b0, st.trig_en, st.mode, st.src, st.run};
            ADDR_W'(A_CNTL): rdata = st.cnt[BYTE_W-1:0];
            ADDR_W'(A_CNTH): rdata = st.cnt[CNT_W-1:BYTE_W];
            ADDR_W'(A_HLDL): rdata = st.hold[BYTE_W-1:0];
            ADDR_W'(A_HLDH): rdata = st.hold[CNT_W-1:BYTE_W];
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/cr_timer.sv
module cr_timer
    import crt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ext_cnt,
    input  logic              ext_trig,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              ovf_flag,
    output logic              trig_flag,
    output logic              baud_tick
);
    crt_state_t        st_q;
    logic [N_PINS-1:0] pins, falls;
    logic              cnt_fall, trg_fall;
    logic              ctl_run, ctl_trig_en;
    logic [1:0]        ctl_mode;
    logic [CNT_W-1:0]  cnt_val, hold_val;

    assign pins = {ext_trig, ext_cnt};

    for (genvar i = 0; i < N_PINS; i++) begin : g_edge
        crt_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_en(tick_en),
            .pin      (pins[i]),
            .fall     (falls[i])
        );
    end

    assign cnt_fall = falls[0];
    assign trg_fall = falls[1];

    crt_count #(.ADDR_W(ADDR_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_fall(cnt_fall),
        .trg_fall(trg_fall),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .st_q    (st_q)
    );

    crt_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .st   (st_q),
        .addr (reg_addr),
        .rdata(reg_rdata)
    );

    assign ovf_flag    = st_q.ovf;
    assign trig_flag   = st_q.trg;
    assign baud_tick   = st_q.baud;
    assign ctl_run     = st_q.run;
    assign ctl_trig_en = st_q.trig_en;
    assign ctl_mode    = st_q.mode;
    assign cnt_val     = st_q.cnt;
    assign hold_val    = st_q.hold;
endmodule

// File: rtl/crt_checker.sv
module crt_checker
    import crt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              ovf_flag,
    input logic              trig_flag,
    input logic              baud_tick,
    input logic              ctl_run,
    input logic              ctl_trig_en,
    input logic [1:0]        ctl_mode,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  hold_val,
    input logic              trg_fall
);
    logic wr_ctl, wr_cnt, wr_hold;
    assign wr_ctl  = reg_we && (reg_addr == ADDR_W'(A_CTL));
    assign wr_cnt  = reg_we && (reg_addr == ADDR_W'(A_CNTL) || reg_addr == ADDR_W'(A_CNTH));
    assign wr_hold = reg_we && (reg_addr == ADDR_W'(A_HLDL) || reg_addr == ADDR_W'(A_HLDH));

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) && !$past(wr_ctl) |-> !$past(ctl_mode[1])); // R9
    AST_BAUD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(ctl_mode[1])); // R9
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl_run && !wr_cnt && ctl_mode != MODE_RLD) |-> $stable(cnt_val)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(wr_ctl && !reg_wdata[6])); // R10
    AST_TRG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_flag) |-> $past(wr_ctl && !reg_wdata[7])); // R10
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trg_fall && ctl_trig_en && ctl_mode == MODE_CAP && !wr_hold)
        |-> hold_val == $past(cnt_val)); // R6
endmodule

bind cr_timer crt_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ovf_flag   (ovf_flag),
    .trig_flag  (trig_flag),
    .baud_tick  (baud_tick),
    .ctl_run    (ctl_run),
    .ctl_trig_en(ctl_trig_en),
    .ctl_mode   (ctl_mode),
    .cnt_val    (cnt_val),
    .hold_val   (hold_val),
    .trg_fall   (trg_fall)
);

// File: tb/cr_timer_bench.sv
module cr_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, ext_cnt = 1'b0, ext_trig = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ovf_flag, trig_flag, baud_tick;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cr_timer u_cr_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_cnt(ext_cnt),
        .ext_trig(ext_trig), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag),
        .trig_flag(trig_flag), .baud_tick(baud_tick)
    );

    // bench model of the registers defined by the requirements
    logic        m_run, m_src, m_te, m_ovf, m_trg, m_baud, m_pc, m_pt;
    logic [1:0]  m_mode;
    logic [15:0] m_cnt, m_hold;
    string       tag = "R1";

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {m_trg, m_ovf, 1'b0, m_te, m_mode, m_src, m_run};
            3'd1: return m_cnt[7:0];
            3'd2: return m_cnt[15:8];
            3'd3: return m_hold[7:0];
            3'd4: return m_hold[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset();
        m_run = 0; m_src = 0; m_te = 0; m_ovf = 0; m_trg = 0; m_baud = 0;
        m_pc = 0; m_pt = 0; m_mode = 0; m_cnt = 0; m_hold = 0;
    endtask

    task automatic m_step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                          input logic tk, input logic ec, input logic et);
        logic cf, tf, inc, trg, bm, wc, wh;
        logic n_ovf, n_trg;
        logic [15:0] n_cnt, n_hold;
        cf  = tk & m_pc & ~ec;
        tf  = tk & m_pt & ~et;
        bm  = m_mode[1];
        inc = m_run & (m_src ? cf : (bm | tk));
        trg = m_te & tf;
        wc  = we && (a == 3'd1 || a == 3'd2);
        wh  = we && (a == 3'd3 || a == 3'd4);
        n_cnt = m_cnt; n_hold = m_hold; n_ovf = m_ovf; n_trg = m_trg;
        tag = "R2";
        m_baud = 0;
        if (inc) tag = m_src ? "R4" : "R3";
        if (we && a == 3'd0) begin
            n_ovf = wd[6]; n_trg = wd[7];
            tag = "R10";
        end
        if (wc) begin
            if (a == 3'd1) n_cnt[7:0] = wd; else n_cnt[15:8] = wd;
            if (inc || (trg && m_mode == 2'b01)) tag = "R11";
        end else if (m_mode == 2'b01 && trg) begin
            n_cnt = m_hold; tag = "R8";
        end else if (inc) begin
            if (m_cnt == 16'hFFFF) begin
                if (m_mode == 2'b00) begin n_cnt = 0; n_ovf = 1; tag = "R5"; end
                else if (!bm) begin n_cnt = m_hold; n_ovf = 1; tag = "R7"; end
                else begin n_cnt = m_hold; m_baud = 1; tag = "R9"; end
            end else n_cnt = m_cnt + 1;
        end
        if (wh) begin
            if (a == 3'd3) n_hold[7:0] = wd; else n_hold[15:8] = wd;
            if (trg && m_mode == 2'b00) tag = "R11";
        end else if (m_mode == 2'b00 && trg) begin
            n_hold = m_cnt; tag = "R6";
        end
        if (trg) begin n_trg = 1; if (bm) tag = "R9"; end
        if (we && a == 3'd0) begin
            m_run = wd[0]; m_src = wd[1]; m_mode = wd[3:2]; m_te = wd[4];
        end
        m_cnt = n_cnt; m_hold = n_hold; m_ovf = n_ovf; m_trg = n_trg;
        if (tk) begin m_pc = ec; m_pt = et; end
    endtask

    task automatic check(input string t, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare, then advance the model
    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] wd,
                       input logic tk, input logic ec, input logic et);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd; tick_en = tk; ext_cnt = ec; ext_trig = et;
        #1;
        check((a > 3'd4) ? "R2" : tag, "rdata", int'(reg_rdata), int'(m_read(a)));
        check(tag, "ovf_flag", int'(ovf_flag), int'(m_ovf));
        check(tag, "trig_flag", int'(trig_flag), int'(m_trg));
        check(tag, "baud_tick", int'(baud_tick), int'(m_baud));
        if (rst_n) m_step(we, a, wd, tk, ec, et);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] wd);
        cyc(1'b1, a, wd, 1'b0, ext_cnt, ext_trig);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'(i % 5), 8'h00, tk, ext_cnt, ext_trig);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1'b0, 3'(i), 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), 8'h00, 1'b0, 1'b0, 1'b0);

        // R2: writes to unused addresses change nothing
        wr(3'd5, 8'hFF); wr(3'd7, 8'hAA);
        for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), 8'h00, 1'b0, 1'b0, 1'b0);

        // R3: run off then on, internal source, capture mode
        wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
        idle(4, 1'b1);
        wr(3'd0, 8'h01);
        idle(6, 1'b1);                       // R5 wrap and overflow
        // R11: count write collides with a step
        cyc(1'b1, 3'd1, 8'h55, 1'b1, 1'b0, 1'b0);
        idle(2, 1'b0);
        // R10: clear flag in same cycle as a fresh overflow
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        cyc(1'b1, 3'd0, 8'h01, 1'b1, 1'b0, 1'b0);
        idle(3, 1'b0);
        // R8: reload by trigger with run off
        wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        wr(3'd0, 8'h14);
        cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0);
        idle(3, 1'b0);
        // R9: baud mode with hold near top
        wr(3'd3, 8'hFC); wr(3'd4, 8'hFF); wr(3'd0, 8'h09);
        idle(12, 1'b0);

        // random phases over every mode, source and trigger enable
        for (int p = 0; p < 16; p++) begin
            logic [7:0] c;
            c = {3'b000, p[0], p[2:1] == 2'b11 ? 2'b10 : p[2:1], p[3], 1'b1};
            wr(3'd3, 8'($urandom_range(240, 255))); wr(3'd4, 8'hFF);
            wr(3'd1, 8'hF0); wr(3'd2, 8'hFF);
            wr(3'd0, c);
            for (int i = 0; i < 400; i++) begin
                logic we;
                logic [2:0] a;
                we = ($urandom_range(0, 31) == 0);
                a  = 3'($urandom_range(0, 7));
                if (we && a == 3'd0) cyc(1'b1, 3'd0, {$urandom_range(0, 1) == 1 ? 2'b11 : 2'b00, 1'b0, c[4:0]},
                                         1'b0, ext_cnt, ext_trig);
                else cyc(we, a, 8'($urandom_range(0, 255)), $urandom_range(0, 2) == 0,
                         1'($urandom_range(0, 1)), $urandom_range(0, 3) != 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule